// File: doc/BRIEF.md
# CAN Controller Interrupt Status Flags

This block holds the interrupt status flags of a CAN controller. It watches the 9-bit transmit and receive error counters, event strobes from the protocol engine, and the per-mailbox pending and mask vectors. From these it keeps eight sticky flags: bus-off, error passive, transmit warning, receive warning, overload sent, reset done, message received and remote request received. Software reads all eight flags as one byte and drives a single active-high interrupt request line.

The four counter flags are edge-triggered. Each flag sets once when its threshold condition becomes true, and it sets again only after the condition has gone false. The overload, reset and counter flags are write-one-to-clear. The two mailbox flags ignore writes. Each of them stays up until every unmasked bit of its pending vector has been cleared. When a set and a clear happen in the same cycle, the set wins.

Flag byte layout: bit0 bus-off, bit1 error passive, bit2 transmit warning, bit3 receive warning, bit4 overload sent, bit5 reset done, bit6 message received, bit7 remote request.

Top module: `can_irq_status`

## Requirements
- R1: Bit0 (bus-off) sets when `tx_err_cnt` changes from a value below 256 to a value of 256 or more.
- R2: Bit2 (transmit warning) sets when `tx_err_cnt` becomes 96 or more.
- R3: Bit3 (receive warning) sets when `rx_err_cnt` becomes 96 or more.
- R4: Bit1 (error passive) sets when either counter becomes 128 or more.
- R5: A cleared counter flag does not set again while its condition stays true. It sets again only after the condition goes false and then true.
- R6: A write with `wr_en` high clears each of bits 0 to 5 whose `wr_data` bit is 1. A 0 in `wr_data` leaves the flag unchanged.
- R7: A one-cycle `ovl_sent` pulse sets bit4 (overload sent).
- R8: After reset the flag byte reads 0x20, so only reset done is set. A `reinit_done` pulse sets bit5 again.
- R9: Bit6 (message received) sets on an `rx_done` pulse when `mbx_mask[rx_mbx]` is 0, for data and remote frames alike. It does not set when the mask bit is 1. Writes have no effect on bit6 or bit7.
- R10: Bit6 clears in the cycle after `rx_pend & ~mbx_mask` becomes zero, and it stays set while that value is nonzero.
- R11: Bit7 (remote request) sets on an `rx_done` pulse with `rx_remote` high into an unmasked mailbox. It clears once `rmt_pend & ~mbx_mask` becomes zero.
- R12: When a set event and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R13: `irq` is registered and active high. It equals the OR of the flag byte as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_cnt | input | 9 | Transmit error counter |
| rx_err_cnt | input | 9 | Receive error counter |
| ovl_sent | input | 1 | Pulse: overload frame transmitted |
| reinit_done | input | 1 | Pulse: reset processing complete |
| rx_done | input | 1 | Pulse: frame fully stored in a mailbox |
| rx_remote | input | 1 | Qualifies `rx_done`: the frame was a remote frame |
| rx_mbx | input | 4 | Mailbox index of the `rx_done` frame |
| mbx_mask | input | 16 | Per-mailbox mask; 1 excludes the mailbox |
| rx_pend | input | 16 | Receive-complete pending vector |
| rmt_pend | input | 16 | Remote-request pending vector |
| wr_en | input | 1 | Write strobe for flag clears |
| wr_data | input | 8 | Write-one-to-clear data |
| rd_data | output | 8 | Current flag byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Any wrong flag state appears on `rd_data` one cycle after the edge that caused it. The same error reaches `irq` one cycle after that. Two faults are easy to miss in a quick test: a lost edge memory in a counter flag, and a write path that reaches the mailbox flags. To expose them, the bench keeps a condition held true after a clear and writes ones to bits 6 and 7. A set that loses to a clear shows up as a missing flag in the cycle after the collision.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NFLAG    = 8;
  localparam int F_BOFF   = 0;
  localparam int F_PASS   = 1;
  localparam int F_TXWARN = 2;
  localparam int F_RXWARN = 3;
  localparam int F_OVL    = 4;
  localparam int F_RSTD   = 5;
  localparam int F_RXMSG  = 6;
  localparam int F_RMT    = 7;
  localparam int NTHR     = 4;

  // Flags software may clear by writing 1.
  localparam logic [NFLAG-1:0] W1C_MASK = 8'h3F;
  // Value of the flag byte after reset.
  localparam logic [NFLAG-1:0] RST_FLAGS = 8'h20;

  // Counter threshold compare, width-agnostic.
  function automatic logic cnt_ge(input logic [31:0] v, input logic [31:0] lim);
    return v >= lim;
  endfunction

  // Any unmasked pending bit.
  function automatic logic live_pend(input logic [63:0] pend, input logic [63:0] mask);
    return |(pend & ~mask);
  endfunction
endpackage

// File: rtl/can_irq_thr.sv
module can_irq_thr (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic rise_o
);
  logic cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_i;
  end

  assign rise_o = cond_i & ~cond_q;

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R12
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o); // R6
endmodule

// File: rtl/can_irq_mbxflag.sv
module can_irq_mbxflag #(
  parameter int NMBX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic [NMBX-1:0] pend_i,
  input  logic [NMBX-1:0] mask_i,
  output logic            q_o
);
  import can_irq_pkg::*;

  logic pend_live;
  assign pend_live = live_pend(64'(pend_i), 64'(mask_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_o <= 1'b0;
    else if (set_i)      q_o <= 1'b1;
    else if (!pend_live) q_o <= 1'b0;
  end

  AST_MBX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && pend_live) |=> q_o); // R10
  AST_MBX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !pend_live && !set_i) |=> !q_o); // R11
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status #(
  parameter int CNT_W    = 9,
  parameter int NMBX     = 16,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256,
  localparam int MBX_W   = (NMBX > 1) ? $clog2(NMBX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             ovl_sent,
  input  logic             reinit_done,
  input  logic             rx_done,
  input  logic             rx_remote,
  input  logic [MBX_W-1:0] rx_mbx,
  input  logic [NMBX-1:0]  mbx_mask,
  input  logic [NMBX-1:0]  rx_pend,
  input  logic [NMBX-1:0]  rmt_pend,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             irq
);
  import can_irq_pkg::*;

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] clr_req;
  logic [NTHR-1:0]  thr_cond;
  logic [NTHR-1:0]  thr_rise;
  logic             rx_unmasked;
  logic             rx_set;
  logic             rmt_set;

  assign clr_req = wr_en ? (wr_data & W1C_MASK) : '0;

  // Threshold conditions, indexed by flag bit position.
  assign thr_cond[F_BOFF]   = cnt_ge(32'(tx_err_cnt), 32'(BOFF_LIM));
  assign thr_cond[F_PASS]   = cnt_ge(32'(tx_err_cnt), 32'(PASS_LIM)) |
                              cnt_ge(32'(rx_err_cnt), 32'(PASS_LIM));
  assign thr_cond[F_TXWARN] = cnt_ge(32'(tx_err_cnt), 32'(WARN_LIM));
  assign thr_cond[F_RXWARN] = cnt_ge(32'(rx_err_cnt), 32'(WARN_LIM));

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    can_irq_thr u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (thr_cond[g]),
      .rise_o (thr_rise[g])
    );
    can_irq_flag #(.RST_VAL(1'b0)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (thr_rise[g]),
      .clr_i (clr_req[g]),
      .q_o   (flag_q[g])
    );
  end

  can_irq_flag #(.RST_VAL(RST_FLAGS[F_OVL])) u_ovl (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ovl_sent),
    .clr_i (clr_req[F_OVL]),
    .q_o   (flag_q[F_OVL])
  );

  can_irq_flag #(.RST_VAL(RST_FLAGS[F_RSTD])) u_rstd (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (reinit_done),
    .clr_i (clr_req[F_RSTD]),
    .q_o   (flag_q[F_RSTD])
  );

  assign rx_unmasked = ~mbx_mask[rx_mbx];
  assign rx_set      = rx_done & rx_unmasked;
  assign rmt_set     = rx_done & rx_remote & rx_unmasked;

  can_irq_mbxflag #(.NMBX(NMBX)) u_rxmsg (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rx_set),
    .pend_i (rx_pend),
    .mask_i (mbx_mask),
    .q_o    (flag_q[F_RXMSG])
  );

  can_irq_mbxflag #(.NMBX(NMBX)) u_rmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rmt_set),
    .pend_i (rmt_pend),
    .mask_i (mbx_mask),
    .q_o    (flag_q[F_RMT])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= |RST_FLAGS;
    else        irq <= |flag_q;
  end

  assign rd_data = flag_q;

  AST_BOFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_rise[F_BOFF] |=> rd_data[F_BOFF]); // R1
  AST_PASS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_rise[F_PASS] |=> rd_data[F_PASS]); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[F_RXMSG] && rx_done && !rx_unmasked && !$past(rx_set)) |=> !rd_data[F_RXMSG]); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|rd_data)); // R13
endmodule

// File: tb/can_irq_status_tb.sv
module can_irq_status_tb_top;
  localparam time CLK_T = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  tx_err_cnt = '0;
  logic [8:0]  rx_err_cnt = '0;
  logic        ovl_sent = 1'b0;
  logic        reinit_done = 1'b0;
  logic        rx_done = 1'b0;
  logic        rx_remote = 1'b0;
  logic [3:0]  rx_mbx = '0;
  logic [15:0] mbx_mask = '0;
  logic [15:0] rx_pend = '0;
  logic [15:0] rmt_pend = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  can_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .ovl_sent(ovl_sent), .reinit_done(reinit_done), .rx_done(rx_done),
    .rx_remote(rx_remote), .rx_mbx(rx_mbx), .mbx_mask(mbx_mask),
    .rx_pend(rx_pend), .rmt_pend(rmt_pend), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clear(input logic [7:0] bits);
    wr_en = 1'b1; wr_data = bits;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R8 reset flags", rd_data, 8'h20);
    chk("R13 irq after reset", {7'b0, irq}, 8'h01);
    clear(8'h20);
    chk("R6 clear reset flag", rd_data, 8'h00);
    tick();
    chk("R13 irq low one cycle later", {7'b0, irq}, 8'h00);
    reinit_done = 1'b1; tick(); reinit_done = 1'b0;
    chk("R8 reinit pulse sets bit5", rd_data, 8'h20);
    chk("R13 irq still low same cycle", {7'b0, irq}, 8'h00);
    tick();
    chk("R13 irq rises one cycle later", {7'b0, irq}, 8'h01);
    clear(8'h20);
  endtask

  task automatic t_tx_thresholds;
    tx_err_cnt = 9'd95; tick();
    chk("R2 tec=95 no warn", rd_data, 8'h00);
    tx_err_cnt = 9'd96; tick();
    chk("R2 tec=96 warn", rd_data, 8'h04);
    clear(8'h04);
    tick(3);
    chk("R5 no re-set while held", rd_data, 8'h00);
    tx_err_cnt = 9'd0; tick();
    tx_err_cnt = 9'd100; tick();
    chk("R5 re-set after fall and rise", rd_data, 8'h04);
    clear(8'h04);
    tx_err_cnt = 9'd0; tick();
    tx_err_cnt = 9'd128; tick();
    chk("R4 tec=128 passive and warn", rd_data, 8'h06);
    clear(8'h06);
    tx_err_cnt = 9'd255; tick();
    chk("R1 tec=255 no bus-off", rd_data, 8'h00);
    tx_err_cnt = 9'd256; tick();
    chk("R1 tec=256 bus-off", rd_data, 8'h01);
    clear(8'h01);
    tx_err_cnt = 9'd0; tick();
  endtask

  task automatic t_rx_thresholds;
    rx_err_cnt = 9'd96; tick();
    chk("R3 rec=96 warn", rd_data, 8'h08);
    clear(8'h08);
    rx_err_cnt = 9'd200; tick();
    chk("R4 rec=200 passive", rd_data, 8'h02);
    clear(8'h02);
    rx_err_cnt = 9'd0; tick();
    chk("R3 clear held", rd_data, 8'h00);
  endtask

  task automatic t_overload_w0;
    ovl_sent = 1'b1; tick(); ovl_sent = 1'b0;
    chk("R7 overload sets bit4", rd_data, 8'h10);
    clear(8'h00);
    chk("R6 write 0 keeps flag", rd_data, 8'h10);
    clear(8'hEF);
    chk("R6 other ones keep bit4", rd_data, 8'h10);
    clear(8'h10);
    chk("R6 write 1 clears bit4", rd_data, 8'h00);
    ovl_sent = 1'b1; wr_en = 1'b1; wr_data = 8'h10;
    tick();
    ovl_sent = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R12 set beats clear", rd_data, 8'h10);
    clear(8'h10);
  endtask

  task automatic t_mailbox;
    mbx_mask = 16'h0008;
    rx_done = 1'b1; rx_mbx = 4'd3; rx_pend = 16'h0008; tick(); rx_done = 1'b0;
    chk("R9 masked mailbox no set", rd_data, 8'h00);
    rx_done = 1'b1; rx_mbx = 4'd5; rx_pend = 16'h0028; tick(); rx_done = 1'b0;
    chk("R9 unmasked data frame sets bit6", rd_data, 8'h40);
    clear(8'hC0);
    chk("R9 write ignored on bit6", rd_data, 8'h40);
    tick(2);
    chk("R10 held while unmasked pending", rd_data, 8'h40);
    rx_pend = 16'h0008; tick();
    chk("R10 drops when only masked pending left", rd_data, 8'h00);
    rx_pend = 16'h0000;
    rx_done = 1'b1; rx_remote = 1'b1; rx_mbx = 4'd2;
    rx_pend = 16'h0004; rmt_pend = 16'h0004;
    tick();
    rx_done = 1'b0; rx_remote = 1'b0;
    chk("R11 remote frame sets bits 6 and 7", rd_data, 8'hC0);
    clear(8'h80);
    chk("R9 write ignored on bit7", rd_data, 8'hC0);
    rmt_pend = 16'h0000; tick();
    chk("R11 remote flag drops", rd_data, 8'h40);
    rx_pend = 16'h0000; tick();
    chk("R10 message flag drops", rd_data, 8'h00);
    tick();
    chk("R13 irq low after all clear", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_tx_thresholds();
    t_rx_thresholds();
    t_overload_w0();
    t_mailbox();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule